// File: doc/BRIEF.md
# Keyboard-Interrupt GPIO Port

An 8-bit bidirectional port for a small microcontroller. Each pin has a data bit and a direction bit. Every pin that is an input is also watched by a keyboard-interrupt unit. When a pin sees a qualifying edge, its flag in a sticky status register is set. The flags are ORed together, qualified by an enable bit and an external CPU mask, and drive a level interrupt request. Software clears the flags either all at once or one bit at a time.

Pins 6 and 7 always detect falling edges. Pins 0 to 5 each have a polarity bit in the key control register. A pin set to rising-edge detection has its pull-up turned off automatically. Configuring a pin as an output masks it from the interrupt. The status register shares the port's data address and is reached there only while a mux option bit is set.

Top module: `kbd_gpio_port`

## Requirements
- R1: During reset the direction, key control, option and status registers go to 0, `pin_oe` goes to 0 and `irq_req` goes to 0. The data register (`pin_out`) keeps its value through reset.
- R2: A direction bit of 1 at address 1 drives `pin_oe` high for that pin. `pin_out` always carries the data register, which is written at address 0 while the mux bit is 0.
- R3: A pin whose direction bit is 1 never sets its status flag, whatever its input does.
- R4: Pins 6 and 7 set their flag on a high-to-low input transition only. A low-to-high transition leaves the flag unchanged.
- R5: For pins 0 to 5, bit i of the key control register (address 2) selects the polarity: 0 means falling edge and 1 means rising edge. Only the selected polarity sets the flag.
- R6: `pull_en[i]` is 1 exactly when pin i is an input and is not set to rising-edge detection.
- R7: Status flags are sticky. An input change applied before rising edge k sets the flag at edge k+2. This comes from two synchronizer stages and one edge-compare stage.
- R8: Bit 0 of the option register (address 3) is the mux bit. While it is 1, reads at address 0 return the status flags, and writes there affect only the status flags, not the data register. While it is 0, reads at address 0 return the data bit for output pins and the synchronized pin level for input pins.
- R9: Bit 7 of the key control register is the interrupt enable. `irq_req` goes to 1 one cycle after (any flag set) AND enable AND NOT `irq_mask`, and it follows that condition with the same one-cycle delay.
- R10: Writing 1 to bit 1 of the option register clears every status flag in that cycle. This bit always reads back as 0.
- R11: With the mux bit at 1, writing a value at address 0 clears each flag whose bit is 1 in that value and leaves the other flags unchanged.
- R12: If an edge sets a flag in the same cycle that a write clears it, the flag ends up set.
- R13: `bus_rdata` is registered. It shows the register selected by `bus_addr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pull_en | output | 8 | Pad pull-up enables |
| irq_mask | input | 1 | CPU interrupt mask, 1 blocks the request |
| irq_req | output | 1 | Level keyboard interrupt request |

## Verification
The assertions check on every cycle that:
- a masked or flag-free port never raises a request;
- flags never fall except under a clear;
- an output pin never gains a flag;
- the direction register leaves reset with all pins as inputs.

The polarity of each pin group, the pull-up rule, the set-over-clear priority in the same cycle, the address mux and the survival of the data register through reset are shown by the directed scenarios. Each of these needs a specific sequence of pin and bus activity to expose it.

// File: rtl/kbd_gpio_pkg.sv
`timescale 1ns/1ps
package kbd_gpio_pkg;
  localparam int ADR_PORT = 0;
  localparam int ADR_DIR  = 1;
  localparam int ADR_KCTL = 2;
  localparam int ADR_OPT  = 3;
  localparam int OPT_MUX    = 0;
  localparam int OPT_CLRALL = 1;
endpackage

// File: rtl/kbd_sync.sv
`timescale 1ns/1ps
module kbd_sync #(
  parameter int W = 8,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= IDLE;
      cur    <= IDLE;
      prev   <= IDLE;
    end else begin
      meta_q <= raw;
      cur    <= meta_q;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/kbd_edge_detect.sv
`timescale 1ns/1ps
module kbd_edge_detect #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] rise_sel,
  input  logic [W-1:0] is_out,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise   = cur[i] & ~prev[i];
    assign fall   = ~cur[i] & prev[i];
    assign hit[i] = ~is_out[i] & (rise_sel[i] ? rise : fall);
  end
endmodule

// File: rtl/kbd_status.sv
`timescale 1ns/1ps
module kbd_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] stat_q,
  output logic         any_flag
);
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_vec) | set_vec;
  end
  assign any_flag = |stat_q;
endmodule

// File: rtl/kbd_gpio_port.sv
`timescale 1ns/1ps
module kbd_gpio_port
  import kbd_gpio_pkg::*;
#(
  parameter int W      = 8,
  parameter int N_PROG = 6,
  parameter int AW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pull_en,
  input  logic          irq_mask,
  output logic          irq_req
);
  localparam int IE_BIT = W - 1;

  logic [W-1:0]      data_q, ddr_q;
  logic [N_PROG-1:0] edg_q;
  logic              ie_q, mux_q;
  logic [W-1:0]      cur, prev, rise_sel, hit, stat_q, clr_vec;
  logic              any_flag;
  logic              wr_port, wr_dir, wr_kctl, wr_opt, clear_all;

  assign wr_port   = bus_we && (bus_addr == AW'(ADR_PORT));
  assign wr_dir    = bus_we && (bus_addr == AW'(ADR_DIR));
  assign wr_kctl   = bus_we && (bus_addr == AW'(ADR_KCTL));
  assign wr_opt    = bus_we && (bus_addr == AW'(ADR_OPT));
  assign clear_all = wr_opt && bus_wdata[OPT_CLRALL];

  // Data register: deliberately not reset
  always_ff @(posedge clk) begin
    if (wr_port && !mux_q) data_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ddr_q <= '0;
      edg_q <= '0;
      ie_q  <= 1'b0;
      mux_q <= 1'b0;
    end else begin
      if (wr_dir) ddr_q <= bus_wdata;
      if (wr_kctl) begin
        edg_q <= bus_wdata[N_PROG-1:0];
        ie_q  <= bus_wdata[IE_BIT];
      end
      if (wr_opt) mux_q <= bus_wdata[OPT_MUX];
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_sel
    if (i < N_PROG) begin : g_prog
      assign rise_sel[i] = edg_q[i];
    end else begin : g_fixed
      assign rise_sel[i] = 1'b0;
    end
  end

  kbd_sync #(.W(W), .IDLE('1)) u_sync (
    .clk(clk), .rst(rst), .raw(pin_in), .cur(cur), .prev(prev)
  );

  kbd_edge_detect #(.W(W)) u_edge (
    .cur(cur), .prev(prev), .rise_sel(rise_sel), .is_out(ddr_q), .hit(hit)
  );

  always_comb begin
    if (clear_all)              clr_vec = '1;
    else if (wr_port && mux_q)  clr_vec = bus_wdata;
    else                        clr_vec = '0;
  end

  kbd_status #(.W(W)) u_stat (
    .clk(clk), .rst(rst), .set_vec(hit), .clr_vec(clr_vec),
    .stat_q(stat_q), .any_flag(any_flag)
  );

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      AW'(ADR_PORT): rd_mux = mux_q ? stat_q : ((ddr_q & data_q) | (~ddr_q & cur));
      AW'(ADR_DIR):  rd_mux = ddr_q;
      AW'(ADR_KCTL): begin
        rd_mux[N_PROG-1:0] = edg_q;
        rd_mux[IE_BIT]     = ie_q;
      end
      default:       rd_mux[OPT_MUX] = mux_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_req   <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq_req   <= any_flag && ie_q && !irq_mask;
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = ddr_q;
  assign pull_en = ~ddr_q & ~rise_sel;
endmodule

// File: rtl/kbd_gpio_port_chk.sv
`timescale 1ns/1ps
module kbd_gpio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         irq_mask,
  input logic         irq_req,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] ddr_q,
  input logic [W-1:0] clr_vec
);
  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq_req);

  assert_no_flag_no_irq_R9: assert property (@(posedge clk) disable iff (rst)
    !(|stat_q) |=> !irq_req);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr_vec)) == '0));

  assert_output_excluded_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(ddr_q)) == '0));

  assert_dir_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0));
endmodule

bind kbd_gpio_port kbd_gpio_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .irq_mask(irq_mask), .irq_req(irq_req),
  .pin_oe(pin_oe), .stat_q(stat_q), .ddr_q(ddr_q), .clr_vec(clr_vec)
);

// File: tb/kbd_gpio_port_bench.sv
`timescale 1ns/1ps
module kbd_gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata, pin_out, pin_oe, pull_en;
  logic [7:0] pin_in = 8'hFF;
  logic       irq_mask = 1'b1;
  logic       irq_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbd_gpio_port u_kbd_gpio_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
    .irq_mask(irq_mask), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 oe after reset", pin_oe, 8'h00);
    chk("R1 irq after reset", {7'b0, irq_req}, 8'h00);
    rd(2'd1, d); chk("R1 dir reads 0", d, 8'h00);
    rd(2'd2, d); chk("R1 kctl reads 0", d, 8'h00);
    rd(2'd3, d); chk("R1 opt reads 0", d, 8'h00);
    chk("R6 all pulls on", pull_en, 8'hFF);
  endtask

  task automatic t_dir_data();
    logic [7:0] d;
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h0F);
    chk("R2 pin_out", pin_out, 8'hA5);
    chk("R2 pin_oe", pin_oe, 8'h0F);
    chk("R6 pulls on inputs only", pull_en, 8'hF0);
    rd(2'd0, d); chk("R8 R13 mixed port read", d, 8'hF5);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1 data survives reset", pin_out, 8'hA5);
    chk("R1 dir cleared", pin_oe, 8'h00);
  endtask

  task automatic t_fixed_falling();
    logic [7:0] d;
    wr(2'd3, 8'h01);
    pins(8'h7F);
    rd(2'd0, d); chk("R4 R7 pin7 fall sets", d, 8'h80);
    pins(8'hFF);
    rd(2'd0, d); chk("R4 pin7 rise ignored", d, 8'h80);
    pins(8'hBF);
    pins(8'hFF);
    rd(2'd0, d); chk("R4 pin6 fall sets", d, 8'hC0);
    wr(2'd0, 8'h80);
    rd(2'd0, d); chk("R11 w1c one bit", d, 8'h40);
    chk("R8 data unchanged by status write", pin_out, 8'hA5);
  endtask

  task automatic t_prog_edges();
    logic [7:0] d;
    wr(2'd3, 8'h03);
    rd(2'd3, d); chk("R10 clear-all reads 0", d, 8'h01);
    rd(2'd0, d); chk("R10 clear-all", d, 8'h00);
    wr(2'd2, 8'h01);
    chk("R6 rising pin pull off", pull_en, 8'hFE);
    pins(8'hFE);
    rd(2'd0, d); chk("R5 falling ignored when rising selected", d, 8'h00);
    pins(8'hFF);
    rd(2'd0, d); chk("R5 rise sets pin0", d, 8'h01);
    pins(8'hFD);
    pins(8'hFF);
    rd(2'd0, d); chk("R5 default falling pin1", d, 8'h03);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_output_mask();
    logic [7:0] d;
    wr(2'd1, 8'h04);
    pins(8'hFB);
    pins(8'hFF);
    rd(2'd0, d); chk("R3 output pin no flag", d, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(2'd2, 8'h80);
    irq_mask = 1'b1;
    pins(8'hF7);
    rd(2'd0, d); chk("R9 flag set", d, 8'h08);
    chk("R9 masked no irq", {7'b0, irq_req}, 8'h00);
    @(negedge clk); irq_mask = 1'b0;
    @(negedge clk);
    chk("R9 irq one cycle after unmask", {7'b0, irq_req}, 8'h01);
    pins(8'hFF);
    wr(2'd0, 8'h08);
    @(negedge clk);
    chk("R9 R11 irq drops after clear", {7'b0, irq_req}, 8'h00);
    wr(2'd2, 8'h00);
    chk("R9 disabled no irq", {7'b0, irq_req}, 8'h00);
  endtask

  task automatic t_set_priority();
    logic [7:0] d;
    pins(8'hEF);
    pins(8'hFF);
    rd(2'd0, d); chk("R12 pre-set", d, 8'h10);
    @(negedge clk); pin_in = 8'hEF;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h10; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(2'd0, d); chk("R12 set wins over clear", d, 8'h10);
    pins(8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dir_data();
    t_fixed_falling();
    t_prog_edges();
    t_output_mask();
    t_irq();
    t_set_priority();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule